// File: doc/BRIEF.md
# Channel Switchover Step Estimator

Two converter channels take turns sampling one sensor signal. Each channel is calibrated separately, but the calibration leaves a small residual mismatch. That mismatch shows up as a square-wave step every time the active channel changes. This block sits after the per-channel calibration. It receives the corrected sample stream, tagged with the channel that produced each sample and with the sample's position inside the repeating 88-sample schedule.

In the schedule, positions 1 to 43 come from channel A, positions 44 to 87 from channel B, and position 88 from channel A again. The block captures the four signal samples that lie on either side of the two channel changes. From them it forms one step estimate per schedule cycle. This raw estimate is smoothed by a slow first-order filter and then held within a small window.

Every sample leaves one cycle later with the clamped estimate applied: it is subtracted from channel A samples and added to channel B samples. Full signal bandwidth is kept because only the estimate is filtered, never the samples.

The block has two modes:
- **Tracking mode:** the estimate keeps following the mismatch from cycle to cycle.
- **Hold mode:** the block waits through a warm-up period of valid samples, then measures the step once and keeps that value.

A small state machine sequences the modes. It has four states:
- `ST_TRACK`: filtered update at every eligible cycle end.
- `ST_WARM`: counting warm-up samples; boundary capture is off.
- `ST_MEASURE`: waiting for the first complete eligible cycle.
- `ST_HOLD`: the estimate is frozen.

The state machine has five transitions:
- `ST_TRACK` to `ST_WARM` when `hold_mode` is seen high.
- `ST_WARM` to `ST_MEASURE` on the last warm-up sample.
- `ST_MEASURE` to `ST_HOLD` on an eligible cycle end.
- Any other state back to `ST_TRACK` when `hold_mode` is low.
- `ST_TRACK` is the state after reset.

Top module: `sw_step_comp`

## Requirements
- R1: After reset, `out_valid` is 0, `step_est` is 0 and the state machine is in `ST_TRACK`.
- R2: An input sample with `in_valid` high appears on the clock edge after it is accepted, with `out_valid` high and `out_chan` equal to its channel. Channel code 0 is channel A and code 1 is channel B. The output sample is the input minus `step_est` for channel A, and the input plus `step_est` for channel B, where `step_est` is the value in effect when the sample was accepted.
- R3: A corrected result above +32767 saturates to +32767, and one below -32768 saturates to -32768.
- R4: The raw estimate is floor((A43 + A88 - B44 - B87) / 4). A43 and A88 are the channel-A samples at positions 43 and 88; B44 and B87 are the channel-B samples at positions 44 and 87. The cycle ends when the channel-A sample at position 88 is accepted.
- R5: In `ST_TRACK`, at an eligible cycle end the filter state f becomes f + floor((raw - f) / 2^SHIFT), with SHIFT = 4. The new estimate applies from the next accepted sample onward.
- R6: `step_est` is the filter state clamped to ±LIMIT (328). The filter state itself is not clamped.
- R7: A cycle end is eligible only if all four boundary samples of that cycle arrived with `in_ok` high. Otherwise the estimate is left unchanged.
- R8: With `hold_mode` high, the block counts WARMUP (1000) valid samples without capturing boundaries. At the first eligible cycle end after that, it loads the raw estimate directly. From then on `step_est` does not change while `hold_mode` stays high.
- R9: When `hold_mode` goes low, the block returns to `ST_TRACK` on the next edge. Filtering then resumes from the estimate that was held.
- R10: A clock with `in_valid` low produces `out_valid` low and leaves `step_est` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_mode | input | 1 | 1 selects measure-once-and-hold, 0 selects tracking |
| in_valid | input | 1 | Input sample present |
| in_chan | input | 1 | Source channel of the sample (0 = A, 1 = B) |
| in_idx | input | 7 | Position of the sample in the 88-sample schedule (1 to 88) |
| in_sample | input | 16 | Calibrated signed sample |
| in_ok | input | 1 | Sample is trustworthy for step estimation |
| out_valid | output | 1 | Compensated sample present |
| out_chan | output | 1 | Channel of the compensated sample |
| out_sample | output | 16 | Compensated signed sample |
| step_est | output | 16 | Clamped step estimate currently applied |

## Verification
The bench focuses on six situations and on what a faulty design would do in each:
- **Boundary positions:** it checks that the four captured samples are exactly those at positions 43, 44, 87 and 88. A design that took neighbouring samples would settle on the wrong step.
- **Negative sums:** a design that truncated toward zero instead of flooring would be off by one LSB.
- **Invalid boundary sample:** a cycle with one boundary sample marked invalid must leave the estimate untouched. A design that ignored the flag would jump.
- **Large mismatch:** a large mismatch drives the filter beyond the clamp. Clamping inside the filter state, rather than after it, would show up as a different trajectory once the mismatch shrinks again.
- **Near full scale:** samples close to full scale must saturate rather than wrap.
- **Hold-mode sequence:** warm-up, a single load, a frozen value, and then a filtered resume after release. A design that started measuring during warm-up, or kept filtering while held, would report the wrong estimate.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [1:0] {
        ST_TRACK   = 2'd0,
        ST_WARM    = 2'd1,
        ST_MEASURE = 2'd2,
        ST_HOLD    = 2'd3
    } swst_e;

    localparam logic CH_A = 1'b0;
    localparam logic CH_B = 1'b1;

endpackage

// File: rtl/sw_edge_capture.sv
module sw_edge_capture
    import sw_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int IDX_W      = 7,
    parameter int POS_A_PRE  = 43,
    parameter int POS_B_POST = 44,
    parameter int POS_B_PRE  = 87,
    parameter int POS_A_POST = 88,
    localparam int SUM_W     = DATA_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_chan,
    input  logic [IDX_W-1:0]         in_idx,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic                     in_ok,
    input  logic                     cap_en,
    output logic                     cycle_end,
    output logic                     ready,
    output logic signed [SUM_W-1:0]  raw
);

    localparam int   NSLOT = 3;
    localparam int   SLOT_POS [NSLOT] = '{POS_A_PRE, POS_B_POST, POS_B_PRE};
    localparam logic SLOT_CH  [NSLOT] = '{CH_A, CH_B, CH_B};

    logic signed [DATA_W-1:0] slot_v [NSLOT];
    logic [NSLOT-1:0]         seen;

    assign cycle_end = in_valid && (in_chan == CH_A) && (in_idx == IDX_W'(POS_A_POST));

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        logic                     hit;
        logic signed [DATA_W-1:0] val_q;
        logic                     seen_q;

        assign hit = in_valid && in_ok && cap_en &&
                     (in_chan == SLOT_CH[k]) && (in_idx == IDX_W'(SLOT_POS[k]));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q  <= '0;
                seen_q <= 1'b0;
            end else begin
                if (hit) val_q <= in_sample;
                if (cycle_end)  seen_q <= 1'b0;
                else if (hit)   seen_q <= 1'b1;
            end
        end

        assign slot_v[k] = val_q;
        assign seen[k]   = seen_q;
    end

    logic signed [SUM_W-1:0] sum_w;
    assign sum_w = SUM_W'(slot_v[0]) + SUM_W'(in_sample)
                 - SUM_W'(slot_v[1]) - SUM_W'(slot_v[2]);
    assign raw   = sum_w >>> 2;
    assign ready = cycle_end && cap_en && in_ok && (&seen);

endmodule

// File: rtl/sw_step_filter.sv
module sw_step_filter #(
    parameter int DATA_W = 16,
    parameter int SHIFT  = 4,
    parameter int LIMIT  = 328,
    localparam int SUM_W = DATA_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [SUM_W-1:0]  raw,
    input  logic                     do_filt,
    input  logic                     do_load,
    output logic signed [DATA_W-1:0] est
);

    localparam logic signed [SUM_W-1:0] LIM_P = SUM_W'(LIMIT);
    localparam logic signed [SUM_W-1:0] LIM_N = -LIM_P;

    logic signed [SUM_W-1:0] filt_q;
    logic signed [SUM_W:0]   diff;
    logic signed [SUM_W:0]   step;

    assign diff = (SUM_W+1)'(raw) - (SUM_W+1)'(filt_q);
    assign step = diff >>> SHIFT;

    always_ff @(posedge clk) begin
        if (!rst_n)       filt_q <= '0;
        else if (do_load) filt_q <= raw;
        else if (do_filt) filt_q <= filt_q + SUM_W'(step);
    end

    always_comb begin
        if (filt_q > LIM_P)      est = DATA_W'(LIM_P);
        else if (filt_q < LIM_N) est = DATA_W'(LIM_N);
        else                     est = DATA_W'(filt_q);
    end

endmodule

// File: rtl/sw_apply.sv
module sw_apply #(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_chan,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic signed [DATA_W-1:0] est,
    output logic                     out_valid,
    output logic                     out_chan,
    output logic signed [DATA_W-1:0] out_sample
);

    localparam logic signed [DATA_W:0] MAXV = (DATA_W+1)'((2 ** (DATA_W-1)) - 1);
    localparam logic signed [DATA_W:0] MINV = -MAXV - 1;

    logic signed [DATA_W:0]   wide;
    logic signed [DATA_W-1:0] sat;

    assign wide = in_chan ? ((DATA_W+1)'(in_sample) + (DATA_W+1)'(est))
                          : ((DATA_W+1)'(in_sample) - (DATA_W+1)'(est));

    always_comb begin
        if (wide > MAXV)      sat = DATA_W'(MAXV);
        else if (wide < MINV) sat = DATA_W'(MINV);
        else                  sat = DATA_W'(wide);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_chan   <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_chan   <= in_chan;
                out_sample <= sat;
            end
        end
    end

endmodule

// File: rtl/sw_step_comp.sv
module sw_step_comp
    import sw_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int IDX_W      = 7,
    parameter int POS_A_PRE  = 43,
    parameter int POS_B_POST = 44,
    parameter int POS_B_PRE  = 87,
    parameter int POS_A_POST = 88,
    parameter int SHIFT      = 4,
    parameter int LIMIT      = 328,
    parameter int WARMUP     = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hold_mode,
    input  logic                     in_valid,
    input  logic                     in_chan,
    input  logic [IDX_W-1:0]         in_idx,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic                     in_ok,
    output logic                     out_valid,
    output logic                     out_chan,
    output logic signed [DATA_W-1:0] out_sample,
    output logic signed [DATA_W-1:0] step_est
);

    localparam int SUM_W = DATA_W + 2;
    localparam int CNT_W = $clog2(WARMUP + 1);

    swst_e state, state_nx;
    logic [CNT_W-1:0] warm_cnt;
    logic warm_last;
    logic cap_en, do_filt, do_load;
    logic cycle_end, ready;
    logic signed [SUM_W-1:0] raw;

    assign warm_last = in_valid && (warm_cnt == CNT_W'(WARMUP - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_TRACK;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          warm_cnt <= '0;
        else if (state != ST_WARM)           warm_cnt <= '0;
        else if (in_valid && !warm_last)     warm_cnt <= warm_cnt + 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_TRACK:   if (hold_mode) state_nx = ST_WARM;
            ST_WARM:    if (!hold_mode) state_nx = ST_TRACK;
                        else if (warm_last) state_nx = ST_MEASURE;
            ST_MEASURE: if (!hold_mode) state_nx = ST_TRACK;
                        else if (ready) state_nx = ST_HOLD;
            ST_HOLD:    if (!hold_mode) state_nx = ST_TRACK;
            default:    state_nx = ST_TRACK;
        endcase
    end

    always_comb begin
        cap_en  = 1'b1;
        do_filt = 1'b0;
        do_load = 1'b0;
        unique case (state)
            ST_TRACK:   do_filt = ready;
            ST_WARM:    cap_en  = 1'b0;
            ST_MEASURE: do_load = ready;
            ST_HOLD:    ;
            default:    ;
        endcase
    end

    sw_edge_capture #(
        .DATA_W(DATA_W), .IDX_W(IDX_W),
        .POS_A_PRE(POS_A_PRE), .POS_B_POST(POS_B_POST),
        .POS_B_PRE(POS_B_PRE), .POS_A_POST(POS_A_POST)
    ) u_cap (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_chan(in_chan), .in_idx(in_idx),
        .in_sample(in_sample), .in_ok(in_ok), .cap_en(cap_en),
        .cycle_end(cycle_end), .ready(ready), .raw(raw)
    );

    sw_step_filter #(
        .DATA_W(DATA_W), .SHIFT(SHIFT), .LIMIT(LIMIT)
    ) u_filt (
        .clk(clk), .rst_n(rst_n), .raw(raw),
        .do_filt(do_filt), .do_load(do_load), .est(step_est)
    );

    sw_apply #(
        .DATA_W(DATA_W)
    ) u_apply (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_chan(in_chan), .in_sample(in_sample),
        .est(step_est),
        .out_valid(out_valid), .out_chan(out_chan), .out_sample(out_sample)
    );

endmodule

// File: rtl/sw_step_comp_chk.sv
module sw_step_comp_chk
    import sw_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LIMIT  = 328
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     hold_mode,
    input logic                     in_valid,
    input logic                     in_chan,
    input logic                     out_valid,
    input logic                     out_chan,
    input logic signed [DATA_W-1:0] step_est,
    input swst_e                    state
);

    localparam logic signed [DATA_W-1:0] LIM_P = DATA_W'(LIMIT);
    localparam logic signed [DATA_W-1:0] LIM_N = -LIM_P;

    a_r2_out_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_chan == $past(in_chan)));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(step_est)));

    a_r6_within_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (step_est <= LIM_P) && (step_est >= LIM_N));

    a_r8_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && hold_mode) |=> $stable(step_est));

    a_r9_release_track: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_mode |=> (state == ST_TRACK));

endmodule

bind sw_step_comp sw_step_comp_chk #(.DATA_W(DATA_W), .LIMIT(LIMIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .hold_mode(hold_mode),
    .in_valid(in_valid), .in_chan(in_chan),
    .out_valid(out_valid), .out_chan(out_chan),
    .step_est(step_est), .state(state)
);

// File: tb/tb_sw_step_comp.sv
`timescale 1ns/1ps
module tb_sw_step_comp;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_mode = 1'b0;
    logic in_valid = 1'b0;
    logic in_chan = 1'b0;
    logic [6:0] in_idx = '0;
    logic signed [15:0] in_sample = '0;
    logic in_ok = 1'b1;
    logic out_valid, out_chan;
    logic signed [15:0] out_sample, step_est;

    always #2.5 clk = ~clk;

    sw_step_comp dut (
        .clk(clk), .rst_n(rst_n), .hold_mode(hold_mode),
        .in_valid(in_valid), .in_chan(in_chan), .in_idx(in_idx),
        .in_sample(in_sample), .in_ok(in_ok),
        .out_valid(out_valid), .out_chan(out_chan),
        .out_sample(out_sample), .step_est(step_est)
    );

    int vectors = 0;
    int errors = 0;
    string cur_req = "R1";

    // Behavioural reference model
    int m_filt = 0, m_a43 = 0, m_b44 = 0, m_b87 = 0, m_cnt = 0, m_state = 0;
    bit m_s43 = 0, m_s44 = 0, m_s87 = 0;
    bit exp_valid = 0, exp_chan = 0;
    int exp_sample = 0;

    function automatic int clampi(int f);
        if (f > 328) return 328;
        if (f < -328) return -328;
        return f;
    endfunction

    function automatic int sat16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_filt = 0; m_cnt = 0; m_state = 0;
            m_s43 = 0; m_s44 = 0; m_s87 = 0;
            exp_valid = 0; exp_chan = 0; exp_sample = 0;
        end else begin
            int s, est, raw;
            bit cap, endc, rdy;
            s = int'(in_sample);
            est = clampi(m_filt);
            exp_valid = in_valid;
            if (in_valid) begin
                exp_chan = in_chan;
                exp_sample = sat16(in_chan ? s + est : s - est);
            end
            cap = (m_state != 1);
            endc = in_valid && !in_chan && in_idx == 88;
            rdy = endc && cap && in_ok && m_s43 && m_s44 && m_s87;
            raw = (m_a43 + s - m_b44 - m_b87) >>> 2;
            if (rdy && m_state == 0) m_filt = m_filt + ((raw - m_filt) >>> 4);
            if (rdy && m_state == 2) m_filt = raw;
            if (in_valid && in_ok && cap) begin
                if (!in_chan && in_idx == 43) begin m_a43 = s; m_s43 = 1; end
                if (in_chan && in_idx == 44)  begin m_b44 = s; m_s44 = 1; end
                if (in_chan && in_idx == 87)  begin m_b87 = s; m_s87 = 1; end
            end
            if (endc) begin m_s43 = 0; m_s44 = 0; m_s87 = 0; end
            case (m_state)
                0: if (hold_mode) begin m_state = 1; m_cnt = 0; end
                1: if (!hold_mode) m_state = 0;
                   else if (in_valid) begin
                       if (m_cnt == 999) m_state = 2; else m_cnt++;
                   end
                2: if (!hold_mode) m_state = 0; else if (rdy) m_state = 3;
                default: if (!hold_mode) m_state = 0;
            endcase
        end
    end

    task automatic fail_line(string req, string what, int act, int expv);
        errors++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (out_valid !== exp_valid) fail_line("R10", "out_valid", int'(out_valid), int'(exp_valid));
            if (int'(step_est) != clampi(m_filt)) fail_line(cur_req, "step_est", int'(step_est), clampi(m_filt));
            if (exp_valid) begin
                if (out_chan !== exp_chan) fail_line("R2", "out_chan", int'(out_chan), int'(exp_chan));
                if (int'(out_sample) != exp_sample) fail_line(cur_req, "out_sample", int'(out_sample), exp_sample);
            end
        end
    end

    task automatic check(string req, string what, int act, int expv);
        vectors++;
        if (act != expv) fail_line(req, what, act, expv);
    endtask

    task automatic send(bit ch, int idx, int val, bit ok);
        @(negedge clk);
        in_valid = 1'b1; in_chan = ch; in_idx = 7'(idx);
        in_sample = 16'(val); in_ok = ok;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // One 88-position schedule cycle; bad_pos marks one sample invalid
    task automatic run_cycle(int base, int a43, int b44, int b87, int a88, int bad_pos);
        for (int idx = 1; idx <= 88; idx++) begin
            bit ch;
            int v;
            if (idx % 11 == 0) idle();
            ch = (idx >= 44 && idx <= 87);
            v = base + ((idx * 37) % 200) - 100;
            if (idx == 43) v = a43;
            if (idx == 44) v = b44;
            if (idx == 87) v = b87;
            if (idx == 88) v = a88;
            send(ch, idx, v, idx != bad_pos);
        end
        idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "step_est after reset", int'(step_est), 0);
        check("R1", "out_valid after reset", int'(out_valid), 0);

        // R4 / R5: raw = (400+400-0-0)/4 = 200, filt = 200>>>4 = 12
        cur_req = "R5";
        run_cycle(1000, 400, 0, 0, 400, 0);
        check("R5", "first filtered step", int'(step_est), 12);
        // R4: negative sum floors: (-3 + 0 - 0 - 0)/4 -> -1, filt 12 + ((-1-12)>>>4) = 12 - 1 = 11
        cur_req = "R4";
        run_cycle(-500, -3, 0, 0, 0, 0);
        check("R4", "floor of negative raw", int'(step_est), 11);

        // R7: invalid boundary sample blocks the update
        cur_req = "R7";
        run_cycle(200, 8000, -8000, -8000, 8000, 87);
        check("R7", "estimate kept after bad sample", int'(step_est), 11);
        run_cycle(200, 8000, 0, 0, 8000, 43);
        check("R7", "estimate kept after bad A43", int'(step_est), 11);

        // R6: large mismatch saturates the applied estimate at the clamp
        cur_req = "R6";
        for (int c = 0; c < 8; c++) run_cycle(0, 4000, 0, 0, 4000, 0);
        check("R6", "positive clamp", int'(step_est), 328);

        // R3: saturation near full scale (est = 328)
        cur_req = "R3";
        send(1'b1, 10, 32700, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R3", "channel B saturates high", int'(out_sample), 32767);
        send(1'b0, 10, -32700, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R3", "channel A saturates low", int'(out_sample), -32768);
        // R2: plain correction at mid scale
        cur_req = "R2";
        send(1'b0, 5, 1000, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "channel A subtracts", int'(out_sample), 1000 - 328);
        // R10: idle clock gives no output
        cur_req = "R10";
        @(negedge clk);
        check("R10", "idle out_valid", int'(out_valid), 0);

        // R6: drive back down; trajectory checked by the model each clock
        cur_req = "R6";
        for (int c = 0; c < 30; c++) run_cycle(0, -4000, 0, 0, -4000, 0);
        check("R6", "negative clamp", int'(step_est), -328);

        // R8: hold mode, warm-up then single load of raw = (160+160)/4 = 80
        cur_req = "R8";
        hold_mode = 1'b1;
        for (int c = 0; c < 14; c++) run_cycle(300, 160, 0, 0, 160, 0);
        check("R8", "loaded static step", int'(step_est), 80);
        for (int c = 0; c < 3; c++) run_cycle(300, 2000, 0, 0, 2000, 0);
        check("R8", "held step unchanged", int'(step_est), 80);

        // R9: release hold, filtering resumes from 80 toward 1000: 80 + (920>>>4) = 137
        cur_req = "R9";
        hold_mode = 1'b0;
        run_cycle(300, 2000, 0, 0, 2000, 0);
        check("R9", "resume tracking", int'(step_est), 137);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule